// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block decides which event starts the next transfer of one DMA channel. Software writes a select register that holds two things. A bank bit chooses between a basic group and an extended group of sixteen causes. A 4-bit code then picks one cause within that group. Every clock cycle the block watches the chosen cause. When it fires, the block sets a pending-request flag, and the transfer engine watches that flag.

Most causes are single-cycle strobes from timers, serial ports, the converter and capture/compare channels. One external interrupt pin is also a cause. The block passes the pin through a synchronizer and detects its edges, so a pin change works like any other strobe. A write-only bit in the select register lets software start a request directly. It only counts when the basic bank and the software code are written together. The transfer engine clears the flag with a one-cycle acknowledge. Software can clear it by writing zero to a status register.

Top module: `dma_cause_sel`

## Requirements
- R1: After reset, the select register (address 0) reads 00h and the pending flag is 0. So the basic bank with the pin falling-edge cause is selected.
- R2: Select register layout at address 0:
  - bits 3:0 hold the cause code.
  - bit 6 holds the bank (0 basic, 1 extended).
  - bits 5:4 always read 0.
  - bit 7 is the software request bit and always reads 0.
- R3: In the basic bank, code 0 selects a falling edge of `pinIn`. The pin passes through two synchronizer flops and an edge flop. A fall driven just after a clock edge shows on `reqPending` after the third following rising edge. A rising edge does not set the flag.
- R4: In the basic bank, code c from 2 to 15 selects `basicEvt[c-2]`. A strobe that is high at a clock edge sets `reqPending` at that edge. Strobes that are not selected have no effect.
- R5: In the extended bank, code 5 selects both edges of `pinIn`, with the same latency as R3. Every other code c selects `extEvt[c]` when c<5 and `extEvt[c-1]` when c>5.
- R6: A write to address 0 with bit 7 set raises a request at that edge only if the written byte also has bit 6 = 0 and bits 3:0 = 0001. Any other write with bit 7 set raises no request. Every write still updates the stored fields.
- R7: Address 1 reads the pending flag in bit 0, and its other bits read 0. Writing a byte with bit 0 = 0 there clears the flag. Writing a byte with bit 0 = 1 leaves it unchanged.
- R8: When `reqAck` is high at an edge, the flag clears at that edge. If the selected cause fires in the same cycle as an acknowledge or a software clear, the cause wins and the flag stays set.
- R9: With no selected cause, no acknowledge and no clear write, the pending flag holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | External interrupt pin, asynchronous |
| basicEvt | input | 14 | Basic-bank event strobes for codes 2..15 |
| extEvt | input | 15 | Extended-bank event strobes for all codes except the pin code |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 = select register, 1 = status register |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr`, combinational |
| reqAck | input | 1 | One-cycle clear from the transfer engine |
| reqPending | output | 1 | Pending DMA request flag |

## Verification
The bench targets the cycle at which a pin edge becomes a request. A synchronizer that is one stage short or long, or an edge detector that also reacts to rising edges in the basic bank, would move or add a request. It writes software-request bytes whose bank or code is wrong by only one bit. A loose decode would then raise a request. It makes events collide with acknowledges and with clear writes. A design that gives the clear priority would drop a real request. Random traffic over both banks checks the mapping from code to strobe on each side of the pin code, where an off-by-one shift would pick a neighbouring strobe.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int DATA_W    = 8;
  localparam int BANK_BIT  = 6;
  localparam int SWREQ_BIT = 7;
  localparam int PEND_BIT  = 0;
  localparam logic [CODE_W-1:0] SW_CODE = CODE_W'(1);

  // strobes from register decode to the datapath
  typedef struct packed {
    logic              selWr;
    logic [CODE_W-1:0] selCode;
    logic              selBank;
    logic              swFire;
    logic              pendClr;
  } dcsStrobe_t;
endpackage

// File: rtl/dcs_pin_edge.sv
module dcs_pin_edge #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic fallEdge,
  output logic anyEdge
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;
  logic              syncOut;

  assign syncOut = syncQ[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= {STAGES{IDLE}};
      prevQ <= IDLE;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], pinIn};
      prevQ <= syncOut;
    end
  end

  assign fallEdge = prevQ & ~syncOut;
  assign anyEdge  = prevQ ^ syncOut;
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CODE_W-1:0] curCode,
  input  logic              curBank,
  input  logic              curPending,
  output logic [DATA_W-1:0] regRdData,
  output dcsStrobe_t        strobe
);
  logic wrSel;
  logic wrStat;

  assign wrSel  = regWrEn && (regAddr == 1'b0);
  assign wrStat = regWrEn && (regAddr == 1'b1);

  always_comb begin
    strobe.selWr   = wrSel;
    strobe.selCode = regWrData[CODE_W-1:0];
    strobe.selBank = regWrData[BANK_BIT];
    strobe.swFire  = wrSel && regWrData[SWREQ_BIT] && !regWrData[BANK_BIT]
                     && (regWrData[CODE_W-1:0] == SW_CODE);
    strobe.pendClr = wrStat && !regWrData[PEND_BIT];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == 1'b0) begin
      regRdData[CODE_W-1:0] = curCode;
      regRdData[BANK_BIT]   = curBank;
    end else begin
      regRdData[PEND_BIT] = curPending;
    end
  end
endmodule

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int   SYNC_STAGES  = 2,
  parameter int   EXT_PIN_CODE = 5,
  parameter logic PIN_IDLE     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinIn,
  input  logic [NUM_CODES-3:0] basicEvt,
  input  logic [NUM_CODES-2:0] extEvt,
  input  logic                 reqAck,
  input  dcsStrobe_t           strobe,
  output logic [CODE_W-1:0]    curCode,
  output logic                 curBank,
  output logic                 curPending,
  output logic                 evtHit
);
  logic                 pinFall;
  logic                 pinAny;
  logic [NUM_CODES-1:0] basicVec;
  logic [NUM_CODES-1:0] extVec;

  dcs_pin_edge #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) i_pin (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .fallEdge(pinFall), .anyEdge(pinAny)
  );

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_basic
    if (c == 0) begin : g_pin
      assign basicVec[c] = pinFall;
    end else if (c == 1) begin : g_sw
      assign basicVec[c] = 1'b0;  // software cause enters through swFire
    end else begin : g_evt
      assign basicVec[c] = basicEvt[c-2];
    end
  end

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_ext
    if (c == EXT_PIN_CODE) begin : g_pin
      assign extVec[c] = pinAny;
    end else if (c < EXT_PIN_CODE) begin : g_lo
      assign extVec[c] = extEvt[c];
    end else begin : g_hi
      assign extVec[c] = extEvt[c-1];
    end
  end

  assign evtHit = (curBank ? extVec[curCode] : basicVec[curCode]) | strobe.swFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCode    <= '0;
      curBank    <= 1'b0;
      curPending <= 1'b0;
    end else begin
      if (strobe.selWr) begin
        curCode <= strobe.selCode;
        curBank <= strobe.selBank;
      end
      if (evtHit)
        curPending <= 1'b1;
      else if (reqAck || strobe.pendClr)
        curPending <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_cause_sel.sv
module dma_cause_sel
  import dcs_pkg::*;
#(
  parameter int   SYNC_STAGES  = 2,
  parameter int   EXT_PIN_CODE = 5,
  parameter logic PIN_IDLE     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinIn,
  input  logic [NUM_CODES-3:0] basicEvt,
  input  logic [NUM_CODES-2:0] extEvt,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 reqAck,
  output logic                 reqPending
);
  dcsStrobe_t        strobe;
  logic [CODE_W-1:0] curCode;
  logic              curBank;
  logic              evtHit;

  dcs_ctrl i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .curCode(curCode), .curBank(curBank), .curPending(reqPending),
    .regRdData(regRdData), .strobe(strobe)
  );

  dcs_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .EXT_PIN_CODE(EXT_PIN_CODE), .PIN_IDLE(PIN_IDLE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .basicEvt(basicEvt), .extEvt(extEvt), .reqAck(reqAck),
    .strobe(strobe), .curCode(curCode), .curBank(curBank),
    .curPending(reqPending), .evtHit(evtHit)
  );
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic       regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       reqAck,
  input logic       reqPending,
  input logic       evtHit
);
  logic clrWr;
  assign clrWr = regWrEn && regAddr && !regWrData[0];

  // R8: a firing cause always leaves the flag set
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    evtHit |=> reqPending);

  // R8: acknowledge without a cause clears
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && !evtHit) |=> !reqPending);

  // R7: writing 1 to the status bit never sets the flag
  a_r7_write_one_inert: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr && regWrData[0] && !evtHit && !reqPending) |=> !reqPending);

  // R9: no cause, no ack, no clear -> flag holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!evtHit && !reqAck && !clrWr) |=> $stable(reqPending));

  // R2: reserved and write-only bits read 0
  a_r2_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdData[7:4] & 4'b1011) == 4'b0000);

  // R7: status register upper bits read 0 and bit 0 mirrors the flag
  a_r7_status_read: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> regRdData == {7'b0, reqPending});
endmodule

bind dma_cause_sel dcs_checker i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .reqAck(reqAck),
  .reqPending(reqPending), .evtHit(evtHit)
);

// File: tb/test_dma_cause_sel.sv
module test_dma_cause_sel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b1;
  logic [13:0] basicEvt = '0;
  logic [14:0] extEvt = '0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        reqAck = 1'b0;
  logic        reqPending;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  logic [3:0] mCode = '0;
  logic       mBank = 1'b0;
  logic       mPend = 1'b0;
  logic       mS0 = 1'b1, mS1 = 1'b1, mPrev = 1'b1;

  always #10 clk = ~clk;

  dma_cause_sel i_dma_cause_sel (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .basicEvt(basicEvt), .extEvt(extEvt),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqAck(reqAck), .reqPending(reqPending)
  );

  function automatic logic causeOf(input logic bank, input logic [3:0] code,
                                   input logic [13:0] bEv, input logic [14:0] eEv,
                                   input logic fall, input logic both);
    if (!bank) begin
      if (code == 0) return fall;
      if (code == 1) return 1'b0;
      return bEv[code-2];
    end
    if (code == 5) return both;
    if (code < 5) return eEv[code];
    return eEv[code-1];
  endfunction

  function automatic logic [7:0] expRead(input logic addr);
    return addr ? {7'b0, mPend} : {1'b0, mBank, 2'b00, mCode};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic fall, both, hit, sw, clr;
    @(posedge clk);
    fall = mPrev & ~mS1;
    both = mPrev ^ mS1;
    sw   = regWrEn && !regAddr && regWrData[7] && !regWrData[6] && regWrData[3:0] == 4'd1;
    clr  = regWrEn && regAddr && !regWrData[0];
    hit  = causeOf(mBank, mCode, basicEvt, extEvt, fall, both) | sw;
    if (hit) mPend = 1'b1;
    else if (reqAck || clr) mPend = 1'b0;
    mPrev = mS1; mS1 = mS0; mS0 = pinIn;
    if (regWrEn && !regAddr) begin
      mCode = regWrData[3:0];
      mBank = regWrData[6];
    end
    @(negedge clk);
    regWrEn = 1'b0; basicEvt = '0; extEvt = '0; reqAck = 1'b0;
  endtask

  task automatic wr(input logic addr, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = addr; regWrData = d;
    tick();
  endtask

  task automatic rd(input string tag, input logic addr, input logic [7:0] exp);
    regAddr = addr;
    #1;
    chk(tag, regRdData, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd("R1 select reset", 1'b0, 8'h00);
    rd("R1 pending reset", 1'b1, 8'h00);

    // R2 layout, R6 wrong bank software request
    wr(1'b0, 8'hFF);
    rd("R2 readback FF", 1'b0, 8'h4F);
    chk("R6 bank1 sw ignored", {7'b0, reqPending}, 8'h00);
    wr(1'b0, 8'h91);  // bit4 set: code 0001 still, bank 0
    chk("R6 sw code 0001", {7'b0, reqPending}, 8'h01);
    rd("R2 bit7/5/4 read 0", 1'b0, 8'h01);
    // R7 write 1 no effect, write 0 clears
    wr(1'b1, 8'hFF);
    chk("R7 write one keeps", {7'b0, reqPending}, 8'h01);
    wr(1'b1, 8'hFE);
    chk("R7 write zero clears", {7'b0, reqPending}, 8'h00);
    wr(1'b0, 8'h83);  // code 3: no software request
    chk("R6 code 3 sw ignored", {7'b0, reqPending}, 8'h00);

    // R3 falling edge latency, rising ignored
    wr(1'b0, 8'h00);
    pinIn = 1'b0;
    tick(); tick();
    chk("R3 not before third edge", {7'b0, reqPending}, 8'h00);
    tick();
    chk("R3 fall at third edge", {7'b0, reqPending}, 8'h01);
    wr(1'b1, 8'h00);
    pinIn = 1'b1;
    repeat (5) tick();
    chk("R3 rise ignored", {7'b0, reqPending}, 8'h00);

    // R5 both edges in extended bank
    wr(1'b0, 8'h45);
    pinIn = 1'b0;
    repeat (3) tick();
    chk("R5 ext fall", {7'b0, reqPending}, 8'h01);
    reqAck = 1'b1; tick();
    chk("R8 ack clears", {7'b0, reqPending}, 8'h00);
    pinIn = 1'b1;
    repeat (3) tick();
    chk("R5 ext rise", {7'b0, reqPending}, 8'h01);
    reqAck = 1'b1; tick();

    // R4 basic strobe mapping, unselected ignored
    wr(1'b0, 8'h07);
    basicEvt[4] = 1'b1; tick();
    chk("R4 unselected ignored", {7'b0, reqPending}, 8'h00);
    basicEvt[5] = 1'b1; tick();
    chk("R4 selected strobe", {7'b0, reqPending}, 8'h01);

    // R8 event wins over ack and over clear write
    reqAck = 1'b1; basicEvt[5] = 1'b1; tick();
    chk("R8 event beats ack", {7'b0, reqPending}, 8'h01);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 8'h00; basicEvt[5] = 1'b1; tick();
    chk("R8 event beats clear", {7'b0, reqPending}, 8'h01);
    reqAck = 1'b1; tick();

    // R5 extended mapping above and below pin code
    wr(1'b0, 8'h48);
    extEvt[8] = 1'b1; tick();
    chk("R5 ext neighbour ignored", {7'b0, reqPending}, 8'h00);
    extEvt[7] = 1'b1; tick();
    chk("R5 ext code 8", {7'b0, reqPending}, 8'h01);
    reqAck = 1'b1; tick();
    wr(1'b0, 8'h44);
    extEvt[4] = 1'b1; tick();
    chk("R5 ext code 4", {7'b0, reqPending}, 8'h01);
    reqAck = 1'b1; tick();

    // random traffic, model comparison (R4 R5 R9)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) basicEvt = 14'(1) << ($urandom % 14);
      if ($urandom % 6 == 0) extEvt = 15'(1) << ($urandom % 15);
      if ($urandom % 10 == 0) pinIn = ~pinIn;
      reqAck = ($urandom % 9 == 0);
      if ($urandom % 25 == 0) begin
        regWrEn = 1'b1; regAddr = 1'b0;
        regWrData = 8'($urandom);
        if ($urandom % 3 == 0) regWrData = {1'b1, 3'($urandom), 4'd1};
      end else if ($urandom % 30 == 0) begin
        regWrEn = 1'b1; regAddr = 1'b1; regWrData = 8'($urandom);
      end else begin
        regAddr = 1'($urandom);
      end
      tick();
      chk("R9 pending vs model", {7'b0, reqPending}, {7'b0, mPend});
      if (i % 16 == 0) rd("R2 read vs model", regAddr, expRead(regAddr));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule